// File: doc/BRIEF.md
# Automatic Status Polling Matcher

This block runs the automatic status-poll mode of a serial flash controller. Once the host selects the polling mode and pulses a start strobe, it asks an external serial shifter for a short read frame. When the shifter reports the frame done, the block keeps the received value, checks it against a programmable mask and match value, and waits a programmable number of cycles before it asks for the next frame. A frame is never longer than four bytes, whatever data length the host programmed.

A masked bit is a candidate when its mask bit is set and its byte lane was actually received. The host picks one of two rules. The all-bits rule matches when every candidate bit equals its match bit. The any-bit rule matches when at least one candidate bit equals its match bit. A match sets a sticky flag that drives an interrupt when enabled. It can also stop the polling loop without host action. The most recent received value is always visible to the host, whether or not it matched.

Top module: `status_poll_matcher`

## Requirements
- R1: Polling runs only while `mode_i` equals 2'b10. A `start_i` pulse under any other mode is ignored. If the mode leaves 2'b10, `req_o` and `busy_o` are low from the next cycle on.
- R2: While `req_o` is high, `req_bytes_o` shows the frame length in bytes. This is `dlen_i + 1` capped at 4, taken from the `dlen_i` value present in the cycle the frame was launched.
- R3: After each completed frame that does not stop polling, `req_o` stays low for exactly `interval_i` cycles and then rises again. With `interval_i` = 0, `req_o` stays high and the next frame follows at once.
- R4: Only received byte lanes take part in the comparison. Lane k covers bits 8k+7..8k and is received when k < `req_bytes_o`. Bits in lanes that were not received count as masked off.
- R5: With `rule_i` = 0 (all-bits rule), a frame matches when every candidate bit equals the same bit of `match_i`. An empty candidate set matches.
- R6: With `rule_i` = 1 (any-bit rule), a frame matches when at least one candidate bit equals the same bit of `match_i`. An empty candidate set never matches.
- R7: `match_flag_o` goes high in the cycle after a matching frame completes. It stays high until a `flag_clr_i` pulse clears it. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq_o` is high exactly when `match_flag_o` is high and `irq_en_i` is high.
- R9: If `auto_stop_i` is high, a matching frame ends polling, and `req_o` and `busy_o` fall in the next cycle. If `auto_stop_i` is low, polling continues after a match.
- R10: One cycle after every completed frame, `last_data_o` holds `frame_data_i` of that frame with the lanes that were not received forced to zero. This happens whether or not the frame matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Functional mode; 2'b10 selects polling |
| start_i | input | 1 | One-cycle pulse that launches polling |
| dlen_i | input | LEN_W | Programmed data length minus one |
| interval_i | input | CNT_W | Idle cycles between frames |
| mask_i | input | 8*LANES | Bit mask applied to received data |
| match_i | input | 8*LANES | Value compared against masked bits |
| rule_i | input | 1 | 0 = all-bits rule, 1 = any-bit rule |
| auto_stop_i | input | 1 | Stop polling on a match |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for the match flag |
| frame_done_i | input | 1 | Shifter reports the requested frame complete |
| frame_data_i | input | 8*LANES | Frame data, lane 0 in bits 7..0 |
| req_o | output | 1 | Frame request to the shifter |
| req_bytes_o | output | $clog2(LANES+1) | Bytes requested for the current frame |
| busy_o | output | 1 | Polling loop active |
| last_data_o | output | 8*LANES | Most recent received value |
| match_flag_o | output | 1 | Sticky status-match flag |
| irq_o | output | 1 | Match interrupt |

## Verification
The bench builds the block with `LEN_W` = 4 and `CNT_W` = 4. The narrow length field still lets a programmed length of ten bytes hit the four-byte cap. The narrow interval field keeps every gap short enough to be counted cycle by cycle. Under these settings the bench covers three kinds of case. The first is the gap cases: zero, two and three idle cycles. The second is partial frames, where unreceived lanes must be masked and zeroed. The third is the empty-mask corners of both rules, combined with automatic stop on and off.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} poll_state_e;
  typedef enum logic {RULE_ALL = 1'b0, RULE_ANY = 1'b1} rule_e;
  localparam logic [1:0] MODE_POLL = 2'b10;
  localparam int unsigned MAX_BYTES = 4;
endpackage

// File: rtl/poll_len_clamp.sv
module poll_len_clamp #(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic [LEN_W-1:0] dlen_i,
  output logic [CW-1:0]    bytes_o
);
  always_comb begin
    if (32'(dlen_i) >= LANES - 1) bytes_o = CW'(LANES);
    else                          bytes_o = CW'(dlen_i) + CW'(1);
  end
endmodule

// File: rtl/poll_compare.sv
module poll_compare
  import poll_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW = $clog2(LANES + 1),
  localparam int unsigned DW = 8 * LANES
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] match_i,
  input  logic [CW-1:0] bytes_i,
  input  rule_e         rule_i,
  output logic          hit_o,
  output logic [DW-1:0] kept_o
);
  logic [DW-1:0] lane_bits;
  logic [DW-1:0] eff_mask;
  logic [DW-1:0] same;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{bytes_i > CW'(g)}};
  end

  assign eff_mask = mask_i & lane_bits;
  assign same     = ~(data_i ^ match_i);
  assign kept_o   = data_i & lane_bits;

  always_comb begin
    if (rule_i == RULE_ANY) hit_o = |(same & eff_mask);
    else                    hit_o = &(same | ~eff_mask);
  end
endmodule

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  // last wait cycle when one count remains
  assign done_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import poll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic poll_mode_i,
  input  logic start_i,
  input  logic frame_done_i,
  input  logic hit_i,
  input  logic auto_stop_i,
  input  logic zero_gap_i,
  input  logic gap_done_i,
  output logic req_o,
  output logic busy_o,
  output logic capture_o,
  output logic launch_o,
  output logic tick_o
);
  poll_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i && poll_mode_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!poll_mode_i)                  state_d = ST_IDLE;
        else if (frame_done_i) begin
          if (hit_i && auto_stop_i)        state_d = ST_IDLE;
          else if (zero_gap_i)             state_d = ST_REQ;
          else                             state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!poll_mode_i)                  state_d = ST_IDLE;
        else if (gap_done_i)               state_d = ST_REQ;
      end
      default:                             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o     = (state_q == ST_REQ);
  assign busy_o    = (state_q != ST_IDLE);
  assign tick_o    = (state_q == ST_WAIT);
  assign capture_o = (state_q == ST_REQ) && frame_done_i;
  assign launch_o  = (state_d == ST_REQ) && ((state_q != ST_REQ) || frame_done_i);
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher
  import poll_pkg::*;
#(
  parameter int unsigned LANES = poll_pkg::MAX_BYTES,
  parameter int unsigned LEN_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   mode_i,
  input  logic                         start_i,
  input  logic [LEN_W-1:0]             dlen_i,
  input  logic [CNT_W-1:0]             interval_i,
  input  logic [8*LANES-1:0]           mask_i,
  input  logic [8*LANES-1:0]           match_i,
  input  logic                         rule_i,
  input  logic                         auto_stop_i,
  input  logic                         irq_en_i,
  input  logic                         flag_clr_i,
  input  logic                         frame_done_i,
  input  logic [8*LANES-1:0]           frame_data_i,
  output logic                         req_o,
  output logic [$clog2(LANES+1)-1:0]   req_bytes_o,
  output logic                         busy_o,
  output logic [8*LANES-1:0]           last_data_o,
  output logic                         match_flag_o,
  output logic                         irq_o
);
  localparam int unsigned DW = 8 * LANES;
  localparam int unsigned CW = $clog2(LANES + 1);

  logic          poll_mode;
  logic          hit;
  logic          capture;
  logic          launch;
  logic          tick;
  logic          gap_done;
  logic [CW-1:0] bytes_next;
  logic [CW-1:0] bytes_q;
  logic [DW-1:0] kept;
  logic [DW-1:0] last_q;
  logic          flag_q;
  rule_e         rule;

  assign poll_mode = (mode_i == MODE_POLL);
  assign rule      = rule_e'(rule_i);

  poll_len_clamp #(.LEN_W(LEN_W), .LANES(LANES)) u_clamp (
    .dlen_i (dlen_i),
    .bytes_o(bytes_next)
  );

  poll_compare #(.LANES(LANES)) u_cmp (
    .data_i (frame_data_i),
    .mask_i (mask_i),
    .match_i(match_i),
    .bytes_i(bytes_q),
    .rule_i (rule),
    .hit_o  (hit),
    .kept_o (kept)
  );

  poll_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(capture),
    .val_i (interval_i),
    .tick_i(tick),
    .done_o(gap_done)
  );

  poll_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .poll_mode_i (poll_mode),
    .start_i     (start_i),
    .frame_done_i(frame_done_i),
    .hit_i       (hit),
    .auto_stop_i (auto_stop_i),
    .zero_gap_i  (interval_i == '0),
    .gap_done_i  (gap_done),
    .req_o       (req_o),
    .busy_o      (busy_o),
    .capture_o   (capture),
    .launch_o    (launch),
    .tick_o      (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_q <= CW'(1);
      last_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (launch)               bytes_q <= bytes_next;
      if (capture)              last_q  <= kept;
      if (capture && hit)       flag_q  <= 1'b1;  // set beats clear
      else if (flag_clr_i)      flag_q  <= 1'b0;
    end
  end

  assign req_bytes_o  = bytes_q;
  assign last_data_o  = last_q;
  assign match_flag_o = flag_q;
  assign irq_o        = flag_q & irq_en_i;
endmodule

// File: rtl/poll_checker.sv
module poll_checker
  import poll_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW = $clog2(LANES + 1),
  localparam int unsigned DW = 8 * LANES
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          req_o,
  input logic [CW-1:0] req_bytes_o,
  input logic          busy_o,
  input logic          frame_done_i,
  input logic [DW-1:0] frame_data_i,
  input logic          hit,
  input logic          auto_stop_i,
  input logic          flag_clr_i,
  input logic          match_flag_o,
  input logic          irq_o,
  input logic [DW-1:0] last_data_o
);
  p_req_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(mode_i) == MODE_POLL);

  p_bytes_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_bytes_o >= CW'(1) && req_bytes_o <= CW'(LANES)));

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && frame_done_i && hit) |=> match_flag_o);

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !flag_clr_i) |=> match_flag_o);

  p_irq_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> match_flag_o);

  p_auto_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && frame_done_i && hit && auto_stop_i) |=> (!busy_o && !req_o));

  p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && frame_done_i) |=> last_data_o[7:0] == $past(frame_data_i[7:0]));
endmodule

bind status_poll_matcher poll_checker #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .req_o       (req_o),
  .req_bytes_o (req_bytes_o),
  .busy_o      (busy_o),
  .frame_done_i(frame_done_i),
  .frame_data_i(frame_data_i),
  .hit         (hit),
  .auto_stop_i (auto_stop_i),
  .flag_clr_i  (flag_clr_i),
  .match_flag_o(match_flag_o),
  .irq_o       (irq_o),
  .last_data_o (last_data_o)
);

// File: tb/sim_status_poll_matcher.sv
module sim_status_poll_matcher;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        start = 1'b0;
  logic [3:0]  dlen = '0;
  logic [3:0]  interval = '0;
  logic [31:0] mask = '0, match = '0, fdata = '0;
  logic        rule = 1'b0, auto_stop = 1'b0, irq_en = 1'b0, flag_clr = 1'b0, fdone = 1'b0;
  logic        req, busy, flag, irq;
  logic [2:0]  req_bytes;
  logic [31:0] last_data;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic exp_flag = 1'b0;
  logic [31:0] q_data[$];
  logic        q_flag[$];
  logic        q_irq[$];
  logic        done_q = 1'b0;

  always #2.5 clk = ~clk;

  status_poll_matcher #(.LANES(4), .LEN_W(4), .CNT_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .start_i(start), .dlen_i(dlen),
    .interval_i(interval), .mask_i(mask), .match_i(match), .rule_i(rule),
    .auto_stop_i(auto_stop), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .frame_done_i(fdone), .frame_data_i(fdata), .req_o(req), .req_bytes_o(req_bytes),
    .busy_o(busy), .last_data_o(last_data), .match_flag_o(flag), .irq_o(irq)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [31:0] d, input logic [31:0] m,
                                     input logic [31:0] t, input logic any, input int nb);
    int care = 0, eq = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i] && (i / 8) < nb) begin
        care++;
        if (d[i] == t[i]) eq++;
      end
    end
    return any ? (eq > 0) : (eq == care);
  endfunction

  // monitor: pops expected result one cycle after a completed frame
  always @(posedge clk) done_q <= fdone & req;
  always @(negedge clk) begin
    if (done_q && q_data.size() > 0) begin
      logic [31:0] ed;
      logic ef, ei;
      ed = q_data.pop_front();
      ef = q_flag.pop_front();
      ei = q_irq.pop_front();
      check(last_data === ed, "R10 last data", last_data, ed);
      check(flag === ef, "R7 match flag", 32'(flag), 32'(ef));
      check(irq === ei, "R8 irq", 32'(irq), 32'(ei));
    end
  end

  // driver: wait for a request, predict, push, complete the frame
  task automatic frame(input logic [31:0] d, input int nb);
    int t = 0;
    logic h;
    logic [31:0] kept;
    while (!req && t < 100) begin t++; @(negedge clk); end
    check(req === 1'b1, "R3 request present", 32'(req), 32'd1);
    check(req_bytes === 3'(nb), "R2 frame length", 32'(req_bytes), 32'(nb));
    h = model_hit(d, mask, match, rule, nb);
    kept = '0;
    for (int k = 0; k < nb; k++) kept[k*8 +: 8] = d[k*8 +: 8];
    if (h) exp_flag = 1'b1;
    q_data.push_back(kept);
    q_flag.push_back(exp_flag);
    q_irq.push_back(exp_flag & irq_en);
    fdata = d;
    fdone = 1'b1;
    @(negedge clk);
    fdone = 1'b0;
  endtask

  task automatic gap(input int exp_gap, input string rq);
    int g = 0;
    while (!req && g < 40) begin g++; @(negedge clk); end
    check(g == exp_gap, rq, 32'(g), 32'(exp_gap));
  endtask

  task automatic restart();
    mode = 2'b00;
    @(negedge clk);
    check(req === 1'b0 && busy === 1'b0, "R1 stop on mode exit", 32'({req, busy}), 32'd0);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_flag = 1'b0;
    check(flag === 1'b0 && irq === 1'b0, "R7 flag clear", 32'({flag, irq}), 32'd0);
    mode = 2'b10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req === 1'b1, "R1 start in polling mode", 32'(req), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req === 1'b0 && busy === 1'b0, "R1 reset idle", 32'({req, busy}), 32'd0);
    check(flag === 1'b0 && irq === 1'b0, "R7 reset flag", 32'({flag, irq}), 32'd0);
    check(last_data === 32'd0, "R10 reset data", last_data, 32'd0);

    // R1: start ignored outside polling mode
    mode = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(req === 1'b0 && busy === 1'b0, "R1 start ignored", 32'({req, busy}), 32'd0);

    // all-bits rule, two lanes, gap 3, polling continues after match
    dlen = 4'd1; interval = 4'd3; mask = 32'h0000_00FF; match = 32'h0000_0081;
    rule = 1'b0; irq_en = 1'b1; auto_stop = 1'b0;
    restart();
    frame(32'hAABB_0001, 2); gap(3, "R3 gap of 3");
    frame(32'h1234_5681, 2); gap(3, "R9 continue after match");
    frame(32'h0000_0000, 2); gap(3, "R3 gap repeat");
    check(flag === 1'b1, "R7 flag sticky", 32'(flag), 32'd1);
    // set wins over a simultaneous clear
    flag_clr = 1'b1;
    frame(32'h0000_0081, 2);
    flag_clr = 1'b0;
    @(negedge clk);
    check(flag === 1'b1, "R7 set beats clear", 32'(flag), 32'd1);

    // R2 clamp, zero gap, all four lanes
    dlen = 4'd9; interval = 4'd0; mask = 32'hFFFF_FFFF; match = 32'h0000_0000;
    restart();
    frame(32'h0000_0000, 4); gap(0, "R3 zero gap");
    frame(32'h0100_0000, 4); gap(0, "R3 zero gap again");

    // R4: single lane, upper lanes neither compared nor kept
    dlen = 4'd0; interval = 4'd2;
    restart();
    frame(32'hFFFF_FF00, 1); gap(2, "R4 partial frame gap");
    check(flag === 1'b1, "R4 unreceived lanes masked", 32'(flag), 32'd1);

    // R6 any-bit rule, irq disabled
    dlen = 4'd3; mask = 32'h0000_000F; match = 32'h0000_0005; rule = 1'b1; irq_en = 1'b0;
    restart();
    frame(32'h0000_000A, 4); gap(2, "R6 gap");
    check(flag === 1'b0, "R6 no bit equal", 32'(flag), 32'd0);
    frame(32'h0000_000B, 4); gap(2, "R6 gap 2");
    check(flag === 1'b1 && irq === 1'b0, "R8 irq masked", 32'({flag, irq}), 32'h2);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq === 1'b1, "R8 irq enabled", 32'(irq), 32'd1);

    // R5 empty mask matches, R9 auto stop
    mask = 32'h0; rule = 1'b0; auto_stop = 1'b1;
    restart();
    frame(32'h1357_9BDF, 4);
    check(req === 1'b0 && busy === 1'b0, "R9 auto stop", 32'({req, busy}), 32'd0);
    gap(40, "R9 stays stopped");
    check(flag === 1'b1, "R5 empty mask all-bits matches", 32'(flag), 32'd1);

    // R6 empty mask never matches, polling keeps going
    rule = 1'b1;
    restart();
    frame(32'h1357_9BDF, 4); gap(2, "R6 empty mask keeps polling");
    check(flag === 1'b0, "R6 empty mask no match", 32'(flag), 32'd0);

    // R1 mode exit during the wait
    frame(32'h0, 4);
    mode = 2'b11;
    @(negedge clk);
    check(busy === 1'b0, "R1 exit during wait", 32'(busy), 32'd0);
    repeat (4) @(negedge clk);
    check(req === 1'b0, "R1 no further request", 32'(req), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule